// File: doc/BRIEF.md
# Radio Transceiver Interrupt Flag Register

This block keeps a single 8-bit flag register for a sub-GHz packet radio controller. The register reports readiness of the operating mode, receive and transmit readiness, synthesizer lock, an RSSI threshold crossing, receive timeouts, intermediate-mode activity and sync/address detection. The rest of the transceiver supplies these events and levels as inputs. Each flag has its own rule for setting and clearing, and many of those rules depend on the current operating mode.

Software reads the register through a simple address/data port. It can clear the Rssi flag by writing a one to it. It can also clear the sync flag this way, but only while the radio is in continuous data mode. Every flag is registered, so a condition presented in a cycle shows up in the register after the next rising clock edge.

Top module: `rsf_top`

## Requirements
- R1: On reset the register holds 0x80. When `regAddr` equals FLAG_ADDR (default 0x27) the register reads back on `regRdData` combinationally. Any other address reads 0. Every flag updates on the rising clock edge that follows the cycle in which its inputs are presented.
- R2: Bit 7 (mode ready) clears in any cycle where `opMode` differs from its value in the previous cycle; after reset the previous mode counts as Sleep. Otherwise it sets when the mode's ready condition holds: Sleep (0) always, Standby (1) `xoRunning`, FS (2) `pllLocked`, TX (3) `paRampDone`, RX (4) `rssiSampling`. Codes 5 to 7 have no ready condition.
- R3: Bit 6 sets in RX when `rxSettled` is high and holds while in RX. It reads 0 whenever the mode is not RX.
- R4: Bit 5 sets in TX when `paRampDone` is high and holds while in TX. It reads 0 whenever the mode is not TX.
- R5: Bit 4 follows `pllLocked` while the mode is FS, TX or RX, and is 0 in every other mode.
- R6: Bit 3 sets in RX when `rssiLevel` is strictly greater than `rssiThresh`. Writing a one to bit 3 clears it. It is 0 outside RX.
- R7: Bit 2 sets on `rxStartTimeout` or `rssiThreshTimeout`. It clears when the mode leaves RX (the previous mode was RX and the current one is not) or on `fifoEmptied`; these clears win over a set.
- R8: Bit 1 follows `autoActive`: it sets on entering intermediate mode and clears on leaving it.
- R9: Bit 0 sets on `syncDetected` and clears on leaving RX or on `fifoEmptied`; these clears win over a set. A one written to bit 0 clears it only when `contMode` is 1 (continuous mode). When `contMode` is 0 (packet mode) the write is ignored.
- R10: A hardware set wins over a software clear in the same cycle. Written ones to bits 7, 6, 5, 4, 2 and 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opMode | input | 3 | Operating mode: 0 Sleep, 1 Standby, 2 FS, 3 TX, 4 RX |
| xoRunning | input | 1 | Crystal oscillator running |
| pllLocked | input | 1 | Synthesizer lock status |
| rssiSampling | input | 1 | RSSI sampling has started |
| paRampDone | input | 1 | PA ramp-up complete |
| rxSettled | input | 1 | RSSI, AGC and AFC complete |
| rssiLevel | input | RSSI_W | Measured RSSI value |
| rssiThresh | input | RSSI_W | Programmed RSSI threshold |
| rxStartTimeout | input | 1 | Strobe for the RX-start timeout |
| rssiThreshTimeout | input | 1 | Strobe for the RSSI-threshold timeout |
| autoActive | input | 1 | Intermediate mode active |
| syncDetected | input | 1 | Strobe for sync/address match |
| fifoEmptied | input | 1 | Strobe for FIFO emptied |
| contMode | input | 1 | 1 = continuous data mode, 0 = packet mode |
| regAddr | input | ADDR_W | Register address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data; ones request clears |
| regRdData | output | 8 | Read data |

## Verification
The hardest situations to reach from the ports combine two events in one cycle. One is a write-one-to-clear landing together with a hardware set. The other is a sync clear attempted in packet mode versus continuous mode while the radio sits in RX with the flag already set. Random stimulus keeps each mode for many cycles and drives writes mostly at the flag address. Directed steps then stack the set and the clear into the same cycle in both data modes. A transition out of RX in the same cycle as a timeout strobe is also forced directly.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  typedef enum logic [2:0] {
    MODE_SLEEP = 3'd0,
    MODE_STBY  = 3'd1,
    MODE_FS    = 3'd2,
    MODE_TX    = 3'd3,
    MODE_RX    = 3'd4
  } opMode_e;

  localparam int BIT_MODE_RDY = 7;
  localparam int BIT_RX_RDY   = 6;
  localparam int BIT_TX_RDY   = 5;
  localparam int BIT_PLL      = 4;
  localparam int BIT_RSSI     = 3;
  localparam int BIT_TIMEOUT  = 2;
  localparam int BIT_AUTO     = 1;
  localparam int BIT_SYNC     = 0;

  typedef struct packed {
    logic inRx;
    logic inTx;
    logic synthOn;
    logic modeChanged;
    logic leaveRx;
    logic modeReadyCond;
    logic rssiAbove;
    logic wrHit;
    logic rdHit;
  } ctrlStrobes_t;
endpackage

// File: rtl/rsf_ctrl.sv
module rsf_ctrl
  import rsf_pkg::*;
#(
  parameter int RSSI_W = 8,
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 7'h27
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opMode,
  input  logic              xoRunning,
  input  logic              pllLocked,
  input  logic              rssiSampling,
  input  logic              paRampDone,
  input  logic [RSSI_W-1:0] rssiLevel,
  input  logic [RSSI_W-1:0] rssiThresh,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctrlStrobes_t      strobes
);
  logic [2:0] prevMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevMode <= MODE_SLEEP;
    else       prevMode <= opMode;
  end

  logic readyCond;
  always_comb begin
    case (opMode)
      MODE_SLEEP: readyCond = 1'b1;
      MODE_STBY:  readyCond = xoRunning;
      MODE_FS:    readyCond = pllLocked;
      MODE_TX:    readyCond = paRampDone;
      MODE_RX:    readyCond = rssiSampling;
      default:    readyCond = 1'b0;
    endcase
  end

  always_comb begin
    strobes.inRx          = (opMode == MODE_RX);
    strobes.inTx          = (opMode == MODE_TX);
    strobes.synthOn       = (opMode == MODE_FS) || (opMode == MODE_TX) || (opMode == MODE_RX);
    strobes.modeChanged   = (opMode != prevMode);
    strobes.leaveRx       = (prevMode == MODE_RX) && (opMode != MODE_RX);
    strobes.modeReadyCond = readyCond;
    strobes.rssiAbove     = (rssiLevel > rssiThresh);
    strobes.rdHit         = (regAddr == FLAG_ADDR);
    strobes.wrHit         = regWrEn && (regAddr == FLAG_ADDR);
  end
endmodule

// File: rtl/rsf_datapath.sv
module rsf_datapath
  import rsf_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic         pllLocked,
  input  logic         paRampDone,
  input  logic         rxSettled,
  input  logic         rxStartTimeout,
  input  logic         rssiThreshTimeout,
  input  logic         autoActive,
  input  logic         syncDetected,
  input  logic         fifoEmptied,
  input  logic         contMode,
  input  logic [7:0]   regWrData,
  output logic [7:0]   flagsQ,
  output logic [7:0]   regRdData
);
  localparam logic [7:0] RESET_VAL = 8'h80;

  logic [7:0] flagsD;
  logic       clrRssi;
  logic       clrSync;
  logic       rxFlush;

  always_comb begin
    clrRssi = strobes.wrHit && regWrData[BIT_RSSI];
    clrSync = strobes.wrHit && regWrData[BIT_SYNC] && contMode;
    rxFlush = strobes.leaveRx || fifoEmptied;

    flagsD[BIT_MODE_RDY] = strobes.modeChanged ? 1'b0
                         : (flagsQ[BIT_MODE_RDY] | strobes.modeReadyCond);
    flagsD[BIT_RX_RDY]   = strobes.inRx ? (flagsQ[BIT_RX_RDY] | rxSettled) : 1'b0;
    flagsD[BIT_TX_RDY]   = strobes.inTx ? (flagsQ[BIT_TX_RDY] | paRampDone) : 1'b0;
    flagsD[BIT_PLL]      = strobes.synthOn & pllLocked;
    flagsD[BIT_RSSI]     = strobes.inRx
                         ? ((flagsQ[BIT_RSSI] & ~clrRssi) | strobes.rssiAbove) : 1'b0;
    flagsD[BIT_TIMEOUT]  = rxFlush ? 1'b0
                         : (flagsQ[BIT_TIMEOUT] | rxStartTimeout | rssiThreshTimeout);
    flagsD[BIT_AUTO]     = autoActive;
    flagsD[BIT_SYNC]     = rxFlush ? 1'b0
                         : ((flagsQ[BIT_SYNC] & ~clrSync) | syncDetected);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagsQ <= RESET_VAL;
    else       flagsQ <= flagsD;
  end

  assign regRdData = strobes.rdHit ? flagsQ : 8'h00;
endmodule

// File: rtl/rsf_top.sv
module rsf_top
  import rsf_pkg::*;
#(
  parameter int RSSI_W = 8,
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 7'h27
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opMode,
  input  logic              xoRunning,
  input  logic              pllLocked,
  input  logic              rssiSampling,
  input  logic              paRampDone,
  input  logic              rxSettled,
  input  logic [RSSI_W-1:0] rssiLevel,
  input  logic [RSSI_W-1:0] rssiThresh,
  input  logic              rxStartTimeout,
  input  logic              rssiThreshTimeout,
  input  logic              autoActive,
  input  logic              syncDetected,
  input  logic              fifoEmptied,
  input  logic              contMode,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData
);
  ctrlStrobes_t strobes;
  logic [7:0]   flagsQ;

  rsf_ctrl #(.RSSI_W(RSSI_W), .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .opMode(opMode), .xoRunning(xoRunning),
    .pllLocked(pllLocked), .rssiSampling(rssiSampling), .paRampDone(paRampDone),
    .rssiLevel(rssiLevel), .rssiThresh(rssiThresh), .regAddr(regAddr),
    .regWrEn(regWrEn), .strobes(strobes)
  );

  rsf_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pllLocked(pllLocked),
    .paRampDone(paRampDone), .rxSettled(rxSettled), .rxStartTimeout(rxStartTimeout),
    .rssiThreshTimeout(rssiThreshTimeout), .autoActive(autoActive),
    .syncDetected(syncDetected), .fifoEmptied(fifoEmptied), .contMode(contMode),
    .regWrData(regWrData), .flagsQ(flagsQ), .regRdData(regRdData)
  );
endmodule

// File: rtl/rsf_checker.sv
module rsf_checker #(
  parameter int RSSI_W = 8,
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 7'h27
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        opMode,
  input logic              pllLocked,
  input logic              fifoEmptied,
  input logic [RSSI_W-1:0] rssiLevel,
  input logic [RSSI_W-1:0] rssiThresh,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [7:0]        regWrData,
  input logic [7:0]        flagsQ
);
  logic [2:0] lastMode;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastMode <= 3'd0;
    else       lastMode <= opMode;
  end

  logic synthMode;
  assign synthMode = (opMode == 3'd2) || (opMode == 3'd3) || (opMode == 3'd4);

  p_mode_change_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    (opMode != lastMode) |=> !flagsQ[7]);

  p_rx_ready_only_rx_r3: assert property (@(posedge clk) disable iff (!rstN)
    (opMode != 3'd4) |=> !flagsQ[6]);

  p_tx_ready_only_tx_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opMode != 3'd3) |=> !flagsQ[5]);

  p_pll_follow_r5: assert property (@(posedge clk) disable iff (!rstN)
    synthMode |=> (flagsQ[4] == $past(pllLocked)));

  p_pll_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    !synthMode |=> !flagsQ[4]);

  p_timeout_fifo_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    fifoEmptied |=> !flagsQ[2]);

  p_sync_fifo_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    fifoEmptied |=> !flagsQ[0]);

  p_set_beats_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == FLAG_ADDR && regWrData[3] && opMode == 3'd4
     && rssiLevel > rssiThresh) |=> flagsQ[3]);
endmodule

bind rsf_top rsf_checker #(.RSSI_W(RSSI_W), .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .opMode(opMode), .pllLocked(pllLocked),
  .fifoEmptied(fifoEmptied), .rssiLevel(rssiLevel), .rssiThresh(rssiThresh),
  .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData), .flagsQ(flagsQ)
);

// File: tb/tb_rsf_top.sv
`timescale 1ns/1ps
module tb_rsf_top;
  localparam int RSSI_W = 8;
  localparam int ADDR_W = 7;
  localparam logic [ADDR_W-1:0] FADDR = 7'h27;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] opMode = 3'd0;
  logic xoRunning = 0, pllLocked = 0, rssiSampling = 0, paRampDone = 0, rxSettled = 0;
  logic [RSSI_W-1:0] rssiLevel = '0, rssiThresh = '1;
  logic rxStartTimeout = 0, rssiThreshTimeout = 0, autoActive = 0;
  logic syncDetected = 0, fifoEmptied = 0, contMode = 0;
  logic [ADDR_W-1:0] regAddr = FADDR;
  logic regWrEn = 0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;

  int total = 0;
  int bad = 0;
  logic [7:0] model = 8'h80;
  logic [2:0] mPrev = 3'd0;
  bit done = 0;

  always #5 clk = ~clk;

  rsf_top #(.RSSI_W(RSSI_W), .ADDR_W(ADDR_W), .FLAG_ADDR(FADDR)) dut (.*);

  function automatic string tagOf(input int b);
    case (b)
      7: return "R2";
      6: return "R3";
      5: return "R4";
      4: return "R5";
      3: return "R6";
      2: return "R7";
      1: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [7:0] nextFlags(input logic [7:0] cur, input logic [2:0] prev);
    logic [7:0] n;
    logic inRx, inTx, synth, leave, hit, rdy;
    inRx  = (opMode == 3'd4);
    inTx  = (opMode == 3'd3);
    synth = (opMode == 3'd2) || inTx || inRx;
    leave = (prev == 3'd4) && !inRx;
    hit   = regWrEn && (regAddr == FADDR);
    case (opMode)
      3'd0: rdy = 1'b1;
      3'd1: rdy = xoRunning;
      3'd2: rdy = pllLocked;
      3'd3: rdy = paRampDone;
      3'd4: rdy = rssiSampling;
      default: rdy = 1'b0;
    endcase
    n[7] = (opMode != prev) ? 1'b0 : (cur[7] | rdy);
    n[6] = inRx ? (cur[6] | rxSettled) : 1'b0;
    n[5] = inTx ? (cur[5] | paRampDone) : 1'b0;
    n[4] = synth & pllLocked;
    n[3] = inRx ? ((cur[3] & ~(hit & regWrData[3])) | (rssiLevel > rssiThresh)) : 1'b0;
    n[2] = (leave | fifoEmptied) ? 1'b0 : (cur[2] | rxStartTimeout | rssiThreshTimeout);
    n[1] = autoActive;
    n[0] = (leave | fifoEmptied) ? 1'b0
         : ((cur[0] & ~(hit & regWrData[0] & contMode)) | syncDetected);
    return n;
  endfunction

  task automatic checkByte(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic quiet();
    xoRunning = 0; pllLocked = 0; rssiSampling = 0; paRampDone = 0; rxSettled = 0;
    rxStartTimeout = 0; rssiThreshTimeout = 0; syncDetected = 0; fifoEmptied = 0;
    regWrEn = 0; regWrData = '0; regAddr = FADDR; rssiLevel = '0; rssiThresh = '1;
  endtask

  // advance one edge, then compare every flag against the model
  task automatic tick();
    logic [7:0] got;
    model = nextFlags(model, mPrev);
    mPrev = opMode;
    @(posedge clk);
    @(negedge clk);
    regAddr = FADDR;
    regWrEn = 0;
    #1;
    got = regRdData;
    for (int b = 0; b < 8; b++) begin
      total++;
      if (got[b] !== model[b]) begin
        bad++;
        $display("FAIL %s bit%0d got=%0b exp=%0b", tagOf(b), b, got[b], model[b]);
      end
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    #1 checkByte("R1 reset", regRdData, 8'h80);
    regAddr = 7'h10;
    #1 checkByte("R1 other addr", regRdData, 8'h00);
    regAddr = FADDR;
    @(negedge clk);
    rstN = 1'b1;
    tick();
    checkByte("R1 after reset", regRdData, 8'h80);

    // R2: Standby waits for oscillator
    opMode = 3'd1; tick(); tick();
    xoRunning = 1; tick();
    // R5: FS with lock
    opMode = 3'd2; tick(); pllLocked = 1; tick(); tick();
    // R3/R6/R9: RX, settle, rssi above, sync
    opMode = 3'd4; rssiSampling = 1; tick();
    rxSettled = 1; rssiLevel = 8'd90; rssiThresh = 8'd40; syncDetected = 1; tick();
    quiet(); pllLocked = 1; rssiSampling = 1; tick();
    // R9: packet mode write-one ignored
    contMode = 0; regWrEn = 1; regWrData = 8'hFF; tick();
    checkByte("R9 packet keeps sync/R10 ro bits", regRdData & 8'h01, 8'h01);
    // R9: continuous mode clears
    contMode = 1; regWrEn = 1; regWrData = 8'h01; tick();
    checkByte("R9 cont clear", regRdData & 8'h01, 8'h00);
    // R10: set and clear together, set wins (bit 3 and bit 0)
    syncDetected = 1; rssiLevel = 8'd200; rssiThresh = 8'd10;
    regWrEn = 1; regWrData = 8'h09; tick();
    checkByte("R10 set beats clear", regRdData & 8'h09, 8'h09);
    quiet(); pllLocked = 1;
    // R6: clear by write, rssi equal not above
    rssiLevel = 8'd50; rssiThresh = 8'd50; regWrEn = 1; regWrData = 8'h08; tick();
    checkByte("R6 w1c equal thresh", regRdData & 8'h08, 8'h00);
    // R7: timeout then leave RX with simultaneous timeout strobe
    rxStartTimeout = 1; tick(); quiet();
    opMode = 3'd0; rssiThreshTimeout = 1; syncDetected = 1; tick(); quiet();
    checkByte("R7 leave rx clears", regRdData & 8'h05, 8'h00);
    // R8: intermediate mode
    autoActive = 1; tick(); autoActive = 0; tick();
    // R4: TX
    opMode = 3'd3; tick(); paRampDone = 1; tick(); quiet(); tick();
    // R7: fifo emptied clears timeout
    rxStartTimeout = 1; tick(); quiet(); fifoEmptied = 1; tick(); quiet();
    opMode = 3'd0; tick();

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(15) == 0) opMode = 3'($urandom_range(4));
      if ($urandom_range(31) == 0) contMode = ~contMode;
      if ($urandom_range(19) == 0) autoActive = ~autoActive;
      xoRunning         = ($urandom_range(3) != 0);
      pllLocked         = ($urandom_range(3) != 0);
      rssiSampling      = ($urandom_range(3) == 0);
      paRampDone        = ($urandom_range(3) == 0);
      rxSettled         = ($urandom_range(3) == 0);
      rssiLevel         = 8'($urandom);
      rssiThresh        = 8'($urandom);
      rxStartTimeout    = ($urandom_range(15) == 0);
      rssiThreshTimeout = ($urandom_range(15) == 0);
      syncDetected      = ($urandom_range(7) == 0);
      fifoEmptied       = ($urandom_range(15) == 0);
      regWrEn           = ($urandom_range(3) == 0);
      regAddr           = ($urandom_range(3) != 0) ? FADDR : 7'($urandom);
      regWrData         = 8'($urandom);
      tick();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule